// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block works next to a serial port that carries a time-division-multiplexed frame of up to 128 word slots. The frame logic presents the number of the slot in progress each cycle. For that slot, the block answers three questions. Should the transmit data pin be driven, or left at high impedance? Should a received word be kept, or thrown away? Should that word go through the compander?

Software programs sixteen 32-bit words through a plain write port. These are an enable map and a compand map for each direction. One input pin selects A-law or mu-law, and that choice applies to every companded channel. The block registers the slot number and the frame qualifiers. All strobes follow one clock after their inputs. The shifter, frame-sync generation and the compander arithmetic sit outside this block.

Top module: `tdm_slot_select`

## Requirements
- R1: While reset is asserted, and right after it, every strobe is low and every map bit is zero, so all 128 channels are off.
- R2: A write to `cfg_addr` selects the map group with bits [3:2] (0 transmit enable, 1 transmit compand, 2 receive enable, 3 receive compand) and the word with bits [1:0]. Bit j of word w governs slot 32*w + j.
- R3: One cycle after slot s is presented with `frame_active` high, `tx_drive_oe` is high exactly when transmit enable bit s is set.
- R4: `tx_drive_oe` is low in any cycle that follows a cycle with `frame_active` low.
- R5: `rx_store` rises one cycle after `rx_last_bit` is seen high inside the frame, and only if receive enable bit s is set. A disabled slot never produces it.
- R6: Within one visit to a slot (consecutive cycles with the same slot number), `rx_store` pulses at most once, even if `rx_last_bit` stays high.
- R7: `tx_compand` equals transmit enable bit s AND transmit compand bit s, qualified by the frame, with the same one-cycle delay as R3.
- R8: `rx_compand` equals receive enable bit s AND receive compand bit s, qualified by the frame, with the same one-cycle delay as R3.
- R9: `compand_alaw` repeats `law_is_alaw` one cycle later (1 = A-law, 0 = mu-law).
- R10: A write changes only the addressed word. Its effect shows on the strobes from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map write strobe |
| cfg_addr | input | 4 | Map word address: group in [3:2], word in [1:0] |
| cfg_wdata | input | 32 | Map write data |
| law_is_alaw | input | 1 | Compander law: 1 A-law, 0 mu-law |
| frame_active | input | 1 | High while a frame is in progress |
| slot_idx | input | 7 | Current slot number |
| rx_last_bit | input | 1 | Last bit of the current receive slot has arrived |
| tx_drive_oe | output | 1 | Active-high enable for the transmit data pin |
| tx_compand | output | 1 | Compress the transmit word of this slot |
| rx_store | output | 1 | Write the received word to the receive buffer |
| rx_compand | output | 1 | Expand the received word of this slot |
| compand_alaw | output | 1 | Law applied to companded slots |

## Verification
Two functions can land in the same cycle. The first is the receive-store decision. The second is the suppression of repeated stores within a visit, and a slot change can restart that suppression. The bench holds `rx_last_bit` high across several cycles on one slot, then moves straight to a neighbouring slot while the flag stays high. A store must appear again on the new slot. A map write can also coincide with lookups. Random streams mix in config writes, repeat slots about half the time, and drop the frame now and then. Every output is compared each cycle against a bench model of the maps and the visit state.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
    localparam int TDM_WORDS   = 4;
    localparam int TDM_WORD_W  = 32;
    localparam int TDM_SLOTS   = TDM_WORDS * TDM_WORD_W;
    localparam int TDM_SLOT_W  = $clog2(TDM_SLOTS);
    localparam int TDM_GROUPS  = 4;
    localparam int TDM_GRP_W   = $clog2(TDM_GROUPS);
    localparam int TDM_WIDX_W  = $clog2(TDM_WORDS);
    localparam int TDM_ADDR_W  = TDM_GRP_W + TDM_WIDX_W;

    // map group selected by the upper address bits
    typedef enum logic [TDM_GRP_W-1:0] {
        GRP_TX_EN  = 2'd0,
        GRP_TX_CMP = 2'd1,
        GRP_RX_EN  = 2'd2,
        GRP_RX_CMP = 2'd3
    } cfg_grp_e;

    // per-cycle registered view of the frame logic
    typedef struct packed {
        logic [TDM_SLOT_W-1:0] slot;
        logic                  frame;
        logic                  rx_last;
        logic                  alaw;
        logic                  stored;
    } slot_state_t;
endpackage

// File: rtl/tdm_cfg_bank.sv
module tdm_cfg_bank #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int GROUPS    = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       we,
    input  logic [$clog2(GROUPS)+$clog2(NUM_WORDS)-1:0] addr,
    input  logic [WORD_W-1:0]                          wdata,
    output logic [GROUPS-1:0][NUM_WORDS*WORD_W-1:0]    grp_map
);
    localparam int WIDX_W = $clog2(NUM_WORDS);
    localparam int GRP_W  = $clog2(GROUPS);
    localparam int ADDR_W = GRP_W + WIDX_W;

    logic [WORD_W-1:0] map_d [GROUPS][NUM_WORDS];
    logic [WORD_W-1:0] map_q [GROUPS][NUM_WORDS];

    logic [GRP_W-1:0]  wr_grp;
    logic [WIDX_W-1:0] wr_word;

    assign wr_grp  = addr[ADDR_W-1 -: GRP_W];
    assign wr_word = addr[WIDX_W-1:0];

    always_comb begin
        map_d = map_q;
        if (we) begin
            map_d[wr_grp][wr_word] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '{default: '0};
        end else begin
            map_q <= map_d;
        end
    end

    // flatten each group so that slot n sits at bit n
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            assign grp_map[g][w*WORD_W +: WORD_W] = map_q[g][w];
        end
    end
endmodule

// File: rtl/tdm_slot_lookup.sv
module tdm_slot_lookup #(
    parameter int SLOTS      = 128,
    parameter int SLOT_W     = $clog2(SLOTS),
    parameter bit ONEHOT_MUX = 1'b0
) (
    input  logic [SLOTS-1:0]  en_map,
    input  logic [SLOTS-1:0]  cmp_map,
    input  logic [SLOT_W-1:0] slot,
    output logic              en_hit,
    output logic              cmp_hit
);
    logic en_bit;
    logic cmp_bit;

    if (ONEHOT_MUX) begin : g_onehot
        logic [SLOTS-1:0] sel;
        always_comb begin
            sel = '0;
            sel[slot] = 1'b1;
        end
        assign en_bit  = |(sel & en_map);
        assign cmp_bit = |(sel & cmp_map);
    end else begin : g_index
        assign en_bit  = en_map[slot];
        assign cmp_bit = cmp_map[slot];
    end

    // a compand request only counts on an active channel
    assign en_hit  = en_bit;
    assign cmp_hit = en_bit & cmp_bit;
endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
    import tdm_slot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [TDM_ADDR_W-1:0] cfg_addr,
    input  logic [TDM_WORD_W-1:0] cfg_wdata,
    input  logic                  law_is_alaw,
    input  logic                  frame_active,
    input  logic [TDM_SLOT_W-1:0] slot_idx,
    input  logic                  rx_last_bit,
    output logic                  tx_drive_oe,
    output logic                  tx_compand,
    output logic                  rx_store,
    output logic                  rx_compand,
    output logic                  compand_alaw
);
    logic [TDM_GROUPS-1:0][TDM_SLOTS-1:0] grp_map;
    slot_state_t st_d;
    slot_state_t st_q;
    logic [TDM_SLOT_W-1:0] slot_q;
    logic tx_hit, tx_cmp_hit, rx_hit, rx_cmp_hit;
    logic store_now;

    tdm_cfg_bank #(
        .NUM_WORDS (TDM_WORDS),
        .WORD_W    (TDM_WORD_W),
        .GROUPS    (TDM_GROUPS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .grp_map (grp_map)
    );

    tdm_slot_lookup #(
        .SLOTS      (TDM_SLOTS),
        .SLOT_W     (TDM_SLOT_W),
        .ONEHOT_MUX (1'b0)
    ) u_tx_lu (
        .en_map  (grp_map[GRP_TX_EN]),
        .cmp_map (grp_map[GRP_TX_CMP]),
        .slot    (st_q.slot),
        .en_hit  (tx_hit),
        .cmp_hit (tx_cmp_hit)
    );

    tdm_slot_lookup #(
        .SLOTS      (TDM_SLOTS),
        .SLOT_W     (TDM_SLOT_W),
        .ONEHOT_MUX (1'b0)
    ) u_rx_lu (
        .en_map  (grp_map[GRP_RX_EN]),
        .cmp_map (grp_map[GRP_RX_CMP]),
        .slot    (st_q.slot),
        .en_hit  (rx_hit),
        .cmp_hit (rx_cmp_hit)
    );

    assign slot_q    = st_q.slot;
    assign store_now = st_q.frame & st_q.rx_last & rx_hit & ~st_q.stored;

    always_comb begin
        st_d         = st_q;
        st_d.slot    = slot_idx;
        st_d.frame   = frame_active;
        st_d.rx_last = rx_last_bit;
        st_d.alaw    = law_is_alaw;
        // a new slot number starts a new visit
        st_d.stored  = (slot_idx == st_q.slot) ? (st_q.stored | store_now) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_drive_oe  = st_q.frame & tx_hit;
    assign tx_compand   = st_q.frame & tx_cmp_hit;
    assign rx_compand   = st_q.frame & rx_cmp_hit;
    assign rx_store     = store_now;
    assign compand_alaw = st_q.alaw;
endmodule

// File: rtl/tdm_slot_select_chk.sv
module tdm_slot_select_chk #(
    parameter int SLOT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_active,
    input logic              rx_last_bit,
    input logic              tx_drive_oe,
    input logic              tx_compand,
    input logic              rx_store,
    input logic              rx_compand,
    input logic [SLOT_W-1:0] cur_slot
);
    logic had_edge = 1'b0;

    always_ff @(posedge clk) had_edge <= 1'b1;

    always @(negedge clk) begin
        if (!rst_n && had_edge) begin
            AST_RESET_QUIET: assert (!tx_drive_oe && !tx_compand && !rx_store && !rx_compand); // R1
        end
    end

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !tx_drive_oe); // R4

    AST_TXCMP_IN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_compand |-> tx_drive_oe); // R7

    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |-> ($past(rx_last_bit) && $past(frame_active))); // R5

    AST_ONE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |=> (!rx_store || (cur_slot != $past(cur_slot)))); // R6

    AST_RXCMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !rx_compand); // R8
endmodule

bind tdm_slot_select tdm_slot_select_chk #(
    .SLOT_W (tdm_slot_pkg::TDM_SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .rx_last_bit  (rx_last_bit),
    .tx_drive_oe  (tx_drive_oe),
    .tx_compand   (tx_compand),
    .rx_store     (rx_store),
    .rx_compand   (rx_compand),
    .cur_slot     (slot_q)
);

// File: tb/sim_tdm_slot_select.sv
`timescale 1ns/1ps
module sim_tdm_slot_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic       law_is_alaw = 1'b0;
    logic       frame_active = 1'b0;
    logic [6:0] slot_idx = '0;
    logic       rx_last_bit = 1'b0;
    logic       tx_drive_oe, tx_compand, rx_store, rx_compand, compand_alaw;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model: group 0 tx en, 1 tx cmp, 2 rx en, 3 rx cmp
    logic [3:0][127:0] m = '0;
    logic [6:0] prev_s = '0;
    bit b_stored = 1'b0;

    always #4 clk = ~clk;

    tdm_slot_select u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .law_is_alaw(law_is_alaw),
        .frame_active(frame_active), .slot_idx(slot_idx),
        .rx_last_bit(rx_last_bit), .tx_drive_oe(tx_drive_oe),
        .tx_compand(tx_compand), .rx_store(rx_store),
        .rx_compand(rx_compand), .compand_alaw(compand_alaw)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_bit(int grp, logic [6:0] s);
        return m[grp][s];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // R2/R10: write one map word and mirror it in the model
    task automatic cfg_write(logic [1:0] grp, logic [1:0] word, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {grp, word}; cfg_wdata = data;
        frame_active = 1'b0; rx_last_bit = 1'b0;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        m[grp][word*32 +: 32] = data;
    endtask

    task automatic step(bit f, logic [6:0] s, bit l, bit a);
        bit e_oe, e_tc, e_st, e_rc;
        @(negedge clk);
        frame_active = f; slot_idx = s; rx_last_bit = l; law_is_alaw = a;
        if (s != prev_s) b_stored = 1'b0;
        e_oe = f & exp_bit(0, s);
        e_tc = f & exp_bit(0, s) & exp_bit(1, s);
        e_rc = f & exp_bit(2, s) & exp_bit(3, s);
        e_st = f & l & exp_bit(2, s) & !b_stored;
        b_stored = b_stored | e_st;
        prev_s = s;
        @(posedge clk);
        #2;
        chk(f ? "R3 tx_drive_oe" : "R4 tx_drive_oe", tx_drive_oe, e_oe);
        chk("R7 tx_compand", tx_compand, e_tc);
        chk("R8 rx_compand", rx_compand, e_rc);
        chk("R5/R6 rx_store", rx_store, e_st);
        chk("R9 compand_alaw", compand_alaw, a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5107_c0de));
        // R1: quiet during reset
        repeat (4) @(posedge clk);
        #2;
        chk("R1 oe in reset", tx_drive_oe, 1'b0);
        chk("R1 store in reset", rx_store, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R1: all channels off after reset, even inside a frame
        step(1, 7'd0, 1, 0);
        step(1, 7'd127, 1, 0);
        step(1, 7'd44, 1, 0);

        // R2: rx enable word 1 bit 12 governs slot 44 only
        cfg_write(2'd2, 2'd1, 32'h0000_1000);
        step(1, 7'd44, 1, 0);
        step(1, 7'd45, 1, 0);
        step(1, 7'd12, 1, 0);
        // R6: flag held across one visit gives one pulse
        step(1, 7'd44, 1, 0);
        step(1, 7'd44, 1, 0);
        step(1, 7'd44, 1, 0);
        // R5: disabled neighbour, then back to 44 restarts the visit
        step(1, 7'd43, 1, 0);
        step(1, 7'd44, 1, 1);

        // R7: compand without enable stays low, then rises with enable
        cfg_write(2'd1, 2'd0, 32'h0000_0008);
        step(1, 7'd3, 0, 1);
        cfg_write(2'd0, 2'd0, 32'h0000_0008);
        step(1, 7'd3, 0, 1);
        // R4: frame low releases the pin
        step(0, 7'd3, 0, 0);
        step(1, 7'd3, 0, 0);
        // R8: rx compand on slot 44
        cfg_write(2'd3, 2'd1, 32'hFFFF_FFFF);
        step(1, 7'd44, 0, 0);
        step(1, 7'd45, 0, 0);
        // R10: write to word 2 leaves word 1 alone
        cfg_write(2'd2, 2'd2, 32'h8000_0001);
        step(1, 7'd44, 1, 0);
        step(1, 7'd64, 1, 0);
        step(1, 7'd95, 1, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 25) == 0) begin
                cfg_write(2'($urandom), 2'($urandom), $urandom);
            end else begin
                logic [6:0] s;
                s = (($urandom % 2) == 0) ? prev_s : 7'($urandom);
                step(($urandom % 10) != 0, s, $urandom % 2, $urandom % 2);
            end
        end
        finish_run();
    end
endmodule